// File: doc/BRIEF.md
# Transmit/Receive Byte FIFOs with Threshold Interrupts

This block sits between a simple register bus and a serial two-wire protocol engine. It holds two 16-entry byte FIFOs. Software fills the transmit FIFO and empties the receive FIFO through the bus. The engine drains the transmit FIFO and fills the receive FIFO through a pop/push handshake. Each FIFO has a programmable 4-bit threshold. The block turns the FIFO levels into live interrupt sources.

The block also latches four transaction events that the engine reports as single-cycle pulses, together with a transmit-overrun event. All sources share one scheme: a raw status word, an enable mask, a masked status word, a write-one-to-clear register and a single interrupt line.

Either FIFO can be flushed by a self-clearing command. While a flush runs, every access to that FIFO is ignored. The flush takes a fixed number of cycles.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, both thresholds read 0, the mask reads 0, no latched event is set, the interrupt output is low and the raw status word (address 6) reads 0x33.
- R2: A bus write to address 3 pushes bits [7:0] into the transmit FIFO, and the engine pops bytes in write order. eng_tx_avail is high while the FIFO holds data and is not flushing. The live raw bits are:
  - bit 0: transmit FIFO empty.
  - bit 1: entry count less than or equal to the transmit threshold.
  - bit 2: all 16 entries used.
- R3: A bus write to address 3 while the transmit FIFO holds 16 entries discards the byte and sets latched raw bit 3 (overrun).
- R4: The engine pushes bytes into the receive FIFO, and a bus read of address 4 returns them in order one cycle after the request. A read of an empty receive FIFO returns 0 and changes nothing. The live raw bits are:
  - bit 4: receive FIFO empty.
  - bit 5: entry count greater than or equal to the receive threshold.
  - bit 6: all 16 entries used.
- R5: The transmit threshold (address 1) and receive threshold (address 2) keep only the low 4 bits of a write and read back those bits.
- R6: Input pulses latch raw bits as follows: ev_done sets bit 19, ev_arb_lost sets bit 24, ev_bus_err sets bit 25 and ev_done_nostop sets bit 28.
- R7: A write to address 8 clears each latched bit written as 1, within the clearable set 0x131F007F. Live FIFO bits are not affected. An event arriving in the same cycle as its clear leaves the bit set.
- R8: The mask (address 5) stores bits [28:0], and bits [31:29] read 0. The masked status (address 7) equals raw AND mask. irq is high exactly when the masked status is nonzero.
- R9: Writing 1 to bit 0 (transmit) or bit 1 (receive) of address 0 starts a flush. The same bit reads back 1 for FLUSH_CYCLES cycles and then clears by itself, leaving that FIFO empty.
- R10: While a FIFO is flushing, bus pushes, bus pops, engine pushes and engine pops on it are ignored, and a receive-data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head byte of the transmit FIFO |
| eng_tx_avail | output | 1 | Transmit byte available to the engine |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_room | output | 1 | Receive FIFO can accept a byte |
| ev_done | input | 1 | Pulse: transaction finished with stop |
| ev_done_nostop | input | 1 | Pulse: transaction finished without stop |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_err | input | 1 | Pulse: bus error |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches properties on every cycle:
- an overrun write always latches the overrun bit;
- an event always survives a clear in the same cycle, and a clear with no competing event always takes effect;
- a flushing FIFO never changes its level except to empty;
- a flush never lasts longer than its cycle count;
- empty receive reads yield zero;
- reserved mask bits stay zero.

The byte ordering through both FIFOs, the threshold comparisons at every level and the full/overrun boundary can only be shown by the bench's scenarios. So can the reset image and the exact status word after mixed random traffic, which the bench compares against its own model.

// File: rtl/i2c_fifo_irq_pkg.sv
package i2c_fifo_irq_pkg;
  localparam int BUS_W = 32;

  // Interrupt source bit positions
  localparam int B_TXE    = 0;
  localparam int B_TXNE   = 1;
  localparam int B_TXF    = 2;
  localparam int B_TXOVR  = 3;
  localparam int B_RXE    = 4;
  localparam int B_RXNF   = 5;
  localparam int B_RXF    = 6;
  localparam int B_DONE   = 19;
  localparam int B_ARB    = 24;
  localparam int B_BERR   = 25;
  localparam int B_DONENS = 28;

  localparam logic [BUS_W-1:0] CLR_BITS  = 32'h131F_007F;
  localparam logic [BUS_W-1:0] LAT_BITS  = 32'h1308_0008;
  localparam logic [BUS_W-1:0] MASK_BITS = 32'h1FFF_FFFF;

  // Register word addresses
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TXTHR  = 4'd1;
  localparam logic [3:0] A_RXTHR  = 4'd2;
  localparam logic [3:0] A_TXDATA = 4'd3;
  localparam logic [3:0] A_RXDATA = 4'd4;
  localparam logic [3:0] A_MASK   = 4'd5;
  localparam logic [3:0] A_RAW    = 4'd6;
  localparam logic [3:0] A_MSTAT  = 4'd7;
  localparam logic [3:0] A_CLR    = 4'd8;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + AW'(1);
      if (do_pop)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_q] <= din;
  end
endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
  parameter int CYCLES = 4,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic done
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = busy_q && (cnt_q == CW'(CYCLES - 1));
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q && req) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl import i2c_fifo_irq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] live,
  input  logic [BUS_W-1:0] set_ev,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] raw,
  output logic [BUS_W-1:0] mask,
  output logic [BUS_W-1:0] masked,
  output logic             irq
);
  logic [BUS_W-1:0] lat_q, lat_d, mask_q, mask_d, clr_vec;

  assign clr_vec = clr_we ? (wdata & CLR_BITS) : '0;

  always_comb begin
    lat_d  = ((lat_q & ~clr_vec) | set_ev) & LAT_BITS;
    mask_d = mask_we ? (wdata & MASK_BITS) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= '0;
    end else begin
      lat_q  <= lat_d;
      mask_q <= mask_d;
    end
  end

  assign raw    = live | lat_q;
  assign mask   = mask_q;
  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq import i2c_fifo_irq_pkg::*; #(
  parameter int DEPTH        = 16,
  parameter int WIDTH        = 8,
  parameter int FLUSH_CYCLES = 4,
  parameter int ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              eng_tx_pop,
  output logic [WIDTH-1:0]  eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [WIDTH-1:0]  eng_rx_data,
  output logic              eng_rx_room,
  input  logic              ev_done,
  input  logic              ev_done_nostop,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  output logic              irq
);
  localparam int THR_W = $clog2(DEPTH);
  localparam int CW    = THR_W + 1;

  logic rst_ns;
  logic wr_en, rd_en;
  logic wr_ctrl, wr_txthr, wr_rxthr, wr_txdata, wr_mask, wr_clr, rd_rxdata;
  logic tx_busy, tx_done, rx_busy, rx_done;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_count, rx_count;
  logic [WIDTH-1:0] rx_dout;
  logic [THR_W-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;
  logic tx_ovr_ev;
  logic [BUS_W-1:0] live, set_ev, raw, mask, masked;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_ns));

  assign wr_en     = bus_valid && bus_write;
  assign rd_en     = bus_valid && !bus_write;
  assign wr_ctrl   = wr_en && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_txthr  = wr_en && (bus_addr == ADDR_W'(A_TXTHR));
  assign wr_rxthr  = wr_en && (bus_addr == ADDR_W'(A_RXTHR));
  assign wr_txdata = wr_en && (bus_addr == ADDR_W'(A_TXDATA));
  assign wr_mask   = wr_en && (bus_addr == ADDR_W'(A_MASK));
  assign wr_clr    = wr_en && (bus_addr == ADDR_W'(A_CLR));
  assign rd_rxdata = rd_en && (bus_addr == ADDR_W'(A_RXDATA));

  // Flush sequencers, one per FIFO
  flush_seq #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
    .clk(clk), .rst_n(rst_ns), .req(wr_ctrl && bus_wdata[0]),
    .busy(tx_busy), .done(tx_done));

  flush_seq #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
    .clk(clk), .rst_n(rst_ns), .req(wr_ctrl && bus_wdata[1]),
    .busy(rx_busy), .done(rx_done));

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_ns), .clear(tx_done),
    .push(wr_txdata && !tx_busy), .din(bus_wdata[WIDTH-1:0]),
    .pop(eng_tx_pop && !tx_busy), .dout(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty));

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_ns), .clear(rx_done),
    .push(eng_rx_push && !rx_busy), .din(eng_rx_data),
    .pop(rd_rxdata && !rx_busy), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty));

  assign eng_tx_avail = !tx_empty && !tx_busy;
  assign eng_rx_room  = !rx_full && !rx_busy;
  assign tx_ovr_ev    = wr_txdata && !tx_busy && tx_full;

  // Threshold registers
  always_comb begin
    tx_thr_d = wr_txthr ? bus_wdata[THR_W-1:0] : tx_thr_q;
    rx_thr_d = wr_rxthr ? bus_wdata[THR_W-1:0] : rx_thr_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
    end
  end

  // Interrupt sources
  always_comb begin
    live           = '0;
    live[B_TXE]    = tx_empty;
    live[B_TXNE]   = (tx_count <= CW'(tx_thr_q));
    live[B_TXF]    = tx_full;
    live[B_RXE]    = rx_empty;
    live[B_RXNF]   = (rx_count >= CW'(rx_thr_q));
    live[B_RXF]    = rx_full;
    set_ev           = '0;
    set_ev[B_TXOVR]  = tx_ovr_ev;
    set_ev[B_DONE]   = ev_done;
    set_ev[B_ARB]    = ev_arb_lost;
    set_ev[B_BERR]   = ev_bus_err;
    set_ev[B_DONENS] = ev_done_nostop;
  end

  irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_ns), .live(live), .set_ev(set_ev),
    .clr_we(wr_clr), .mask_we(wr_mask), .wdata(bus_wdata),
    .raw(raw), .mask(mask), .masked(masked), .irq(irq));

  // Read data path
  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL):   rdata_d = BUS_W'({rx_busy, tx_busy});
      ADDR_W'(A_TXTHR):  rdata_d = BUS_W'(tx_thr_q);
      ADDR_W'(A_RXTHR):  rdata_d = BUS_W'(rx_thr_q);
      ADDR_W'(A_RXDATA): rdata_d = (rx_empty || rx_busy) ? '0 : BUS_W'(rx_dout);
      ADDR_W'(A_MASK):   rdata_d = mask;
      ADDR_W'(A_RAW):    rdata_d = raw;
      ADDR_W'(A_MSTAT):  rdata_d = masked;
      default:           rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/i2c_fifo_irq_chk.sv
module i2c_fifo_irq_chk import i2c_fifo_irq_pkg::*; #(
  parameter int DEPTH        = 16,
  parameter int FLUSH_CYCLES = 4,
  parameter int ADDR_W       = 4,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int LW = $clog2(FLUSH_CYCLES + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_full,
  input logic              tx_busy,
  input logic              rx_busy,
  input logic [BUS_W-1:0]  raw,
  input logic              ev_arb_lost
);
  logic wr_tx, wr_clr, rd_rx, rd_mask;
  logic [LW-1:0] tx_len_q, rx_len_q;

  assign wr_tx   = bus_valid && bus_write && (bus_addr == ADDR_W'(A_TXDATA));
  assign wr_clr  = bus_valid && bus_write && (bus_addr == ADDR_W'(A_CLR));
  assign rd_rx   = bus_valid && !bus_write && (bus_addr == ADDR_W'(A_RXDATA));
  assign rd_mask = bus_valid && !bus_write && (bus_addr == ADDR_W'(A_MASK));

  // Consecutive busy cycles seen before the current one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_len_q <= '0;
      rx_len_q <= '0;
    end else begin
      tx_len_q <= tx_busy ? tx_len_q + LW'(1) : '0;
      rx_len_q <= rx_busy ? rx_len_q + LW'(1) : '0;
    end
  end

  a_r3_overrun_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full && !tx_busy) |=> raw[B_TXOVR]);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_count == '0) |=> (bus_rdata == '0));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> raw[B_ARB]);

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[B_ARB] && !ev_arb_lost) |=> !raw[B_ARB]);

  a_r8_mask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mask |=> (bus_rdata[31:29] == 3'b000));

  a_r9_tx_flush_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (tx_len_q < LW'(FLUSH_CYCLES)));

  a_r9_rx_flush_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> (rx_len_q < LW'(FLUSH_CYCLES)));

  a_r10_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (tx_count == $past(tx_count)) || (tx_count == '0));

  a_r10_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> (rx_count == $past(rx_count)) || (rx_count == '0));
endmodule

bind i2c_fifo_irq i2c_fifo_irq_chk #(
  .DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full),
  .tx_busy(tx_busy), .rx_busy(rx_busy), .raw(raw), .ev_arb_lost(ev_arb_lost)
);

// File: tb/i2c_fifo_irq_tb.sv
`timescale 1ns/1ps
module i2c_fifo_irq_tb;
  localparam int FC = 4;

  logic clk, rst_n;
  logic bus_valid, bus_write;
  logic [3:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic eng_tx_pop, eng_tx_avail, eng_rx_push, eng_rx_room;
  logic [7:0] eng_tx_data, eng_rx_data;
  logic ev_done, ev_done_nostop, ev_arb_lost, ev_bus_err, irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [31:0] m_lat = 0, m_mask = 0;
  int m_txthr = 0, m_rxthr = 0;

  i2c_fifo_irq #(.FLUSH_CYCLES(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_room(eng_rx_room),
    .ev_done(ev_done), .ev_done_nostop(ev_done_nostop), .ev_arb_lost(ev_arb_lost),
    .ev_bus_err(ev_bus_err), .irq(irq));

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_raw();
    logic [31:0] r;
    r = m_lat;
    r[0] = (txq.size() == 0);
    r[1] = (txq.size() <= m_txthr);
    r[2] = (txq.size() == 16);
    r[4] = (rxq.size() == 0);
    r[5] = (rxq.size() >= m_rxthr);
    r[6] = (rxq.size() == 16);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic tx_write(input logic [7:0] b);
    bus_wr(4'd3, {24'h0, b});
    if (txq.size() == 16) m_lat[3] = 1;
    else txq.push_back(b);
  endtask

  task automatic eng_pop(input string req);
    check(req, eng_tx_avail, 1);
    check(req, eng_tx_data, txq[0]);
    eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
    void'(txq.pop_front());
  endtask

  task automatic eng_push(input logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 0;
    if (rxq.size() < 16) rxq.push_back(b);
  endtask

  task automatic rx_read(input string req);
    logic [31:0] d;
    logic [7:0] e;
    e = (rxq.size() == 0) ? 8'h00 : rxq.pop_front();
    bus_rd(4'd4, d);
    check(req, d, {24'h0, e});
  endtask

  task automatic check_raw(input string req);
    logic [31:0] d;
    bus_rd(4'd6, d);
    check(req, d, exp_raw());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
    ev_done = 0; ev_done_nostop = 0; ev_arb_lost = 0; ev_bus_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset image
    check("R1 irq", irq, 0);
    bus_rd(4'd6, d); check("R1 raw", d, 32'h33);
    bus_rd(4'd5, d); check("R1 mask", d, 0);
    bus_rd(4'd1, d); check("R1 txthr", d, 0);
    bus_rd(4'd0, d); check("R1 ctrl", d, 0);

    // R5 thresholds truncate to 4 bits
    bus_wr(4'd1, 32'd20); m_txthr = 4;
    bus_rd(4'd1, d); check("R5 txthr", d, 4);
    bus_wr(4'd2, 32'h1F8); m_rxthr = 8;
    bus_rd(4'd2, d); check("R5 rxthr", d, 8);

    // R2/R3 fill TX to full then overrun
    for (int i = 0; i < 16; i++) begin
      tx_write(8'hA0 + 8'(i));
      if (i == 3 || i == 4 || i == 15) check_raw("R2 tx level bits");
    end
    tx_write(8'h55);
    check_raw("R3 overrun latched");
    for (int i = 0; i < 16; i++) eng_pop("R2 tx order");
    check("R2 avail low when empty", eng_tx_avail, 0);
    check_raw("R2 tx empty");

    // R4 RX path
    rx_read("R4 empty read zero");
    check_raw("R4 empty read no change");
    for (int i = 0; i < 9; i++) eng_push(8'h30 + 8'(i));
    check_raw("R4 rx nearly full at threshold");
    for (int i = 0; i < 9; i++) rx_read("R4 rx order");
    for (int i = 0; i < 17; i++) eng_push(8'(i));
    check_raw("R4 rx full");
    check("R4 room low when full", eng_rx_room, 0);
    for (int i = 0; i < 16; i++) rx_read("R4 rx drain");

    // R6 events
    ev_done = 1; @(negedge clk); ev_done = 0; m_lat[19] = 1;
    ev_arb_lost = 1; @(negedge clk); ev_arb_lost = 0; m_lat[24] = 1;
    ev_bus_err = 1; @(negedge clk); ev_bus_err = 0; m_lat[25] = 1;
    ev_done_nostop = 1; @(negedge clk); ev_done_nostop = 0; m_lat[28] = 1;
    check_raw("R6 events latched");

    // R8 mask
    bus_wr(4'd5, 32'hFFFF_FFFF); m_mask = 32'h1FFF_FFFF;
    bus_rd(4'd5, d); check("R8 mask reserved", d, 32'h1FFF_FFFF);
    bus_rd(4'd7, d); check("R8 masked", d, exp_raw() & m_mask);
    check("R8 irq", irq, |(exp_raw() & m_mask));

    // R7 clear, with same-cycle event winning on bit 24
    ev_arb_lost = 1;
    bus_wr(4'd8, 32'hFFFF_FFFF);
    ev_arb_lost = 0;
    m_lat = 32'h0100_0000;
    check_raw("R7 clear keeps live, event wins");
    bus_wr(4'd8, 32'h0100_0000); m_lat = 0;
    check_raw("R7 clear single bit");
    bus_wr(4'd5, 32'h0000_0008); m_mask = 32'h8;
    check("R8 irq low when masked bits quiet", irq, 0);

    // R9/R10 TX flush
    tx_write(8'h11); tx_write(8'h22); tx_write(8'h33);
    bus_wr(4'd0, 32'h1);
    bus_rd(4'd0, d); check("R9 tx busy", d, 1);
    bus_wr(4'd3, 32'h99);
    check("R10 tx avail during flush", eng_tx_avail, 0);
    eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    repeat (FC) @(negedge clk);
    txq.delete();
    bus_rd(4'd0, d); check("R9 tx busy cleared", d, 0);
    check_raw("R9 tx emptied, R10 no overrun");

    // R9/R10 RX flush
    eng_push(8'h44); eng_push(8'h45);
    bus_wr(4'd0, 32'h2);
    bus_rd(4'd4, d); check("R10 rx read during flush", d, 0);
    eng_rx_push = 1; eng_rx_data = 8'h77; @(negedge clk); eng_rx_push = 0;
    bus_rd(4'd0, d); check("R9 rx busy", d, 2);
    repeat (FC) @(negedge clk);
    rxq.delete();
    bus_rd(4'd0, d); check("R9 rx busy cleared", d, 0);
    check_raw("R9 rx emptied, R10 push ignored");

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 8)
        0, 1: tx_write(8'($urandom));
        2: if (txq.size() > 0) eng_pop("R2 random pop");
        3: eng_push(8'($urandom));
        4: rx_read("R4 random read");
        5: begin
          logic [3:0] e;
          e = 4'($urandom);
          ev_done = e[0]; ev_arb_lost = e[1]; ev_bus_err = e[2]; ev_done_nostop = e[3];
          @(negedge clk);
          ev_done = 0; ev_arb_lost = 0; ev_bus_err = 0; ev_done_nostop = 0;
          m_lat[19] |= e[0]; m_lat[24] |= e[1]; m_lat[25] |= e[2]; m_lat[28] |= e[3];
        end
        6: begin
          logic [31:0] c;
          c = $urandom;
          bus_wr(4'd8, c);
          m_lat = m_lat & ~(c & 32'h131F_007F);
        end
        default: begin
          logic [31:0] m;
          m = $urandom;
          bus_wr(4'd5, m);
          m_mask = m & 32'h1FFF_FFFF;
          if (($urandom % 2) == 1) begin
            m_txthr = $urandom % 16; bus_wr(4'd1, 32'(m_txthr));
            m_rxthr = $urandom % 16; bus_wr(4'd2, 32'(m_rxthr));
          end
        end
      endcase
      check("R8 random irq", irq, |(exp_raw() & m_mask));
      check_raw("R7 random raw");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule